// File: doc/BRIEF.md
# System Control Register with Done Handshake

An 8-bit memory-mapped control register for a small microcontroller. It holds five kinds of state. The first is a lock that makes the protected debug and loader routines demand a password match. The second is a "ROM work finished" flag that the control unit acknowledges. The third is an enable that puts user program pages into the upper half of program space. The fourth is a two-bit page selector for data-space access to program memory. The fifth is an enable for the debug test-port pins. The memory mapper and the debug logic read the fields directly from dedicated outputs. The CPU reads and writes the whole byte through a simple select/strobe port.

The finished flag also acts as a handshake. When software writes 1 to it while the external debug-mode flag is high, the block emits a one-cycle system reset request and a one-cycle strobe that clears that flag. The control unit's acknowledge clears the finished flag.

The block has two reset inputs. The power-on reset sets every field, including the lock. The ordinary reset leaves the lock untouched. Both resets assert asynchronously and release through a synchronizer.

Top module: `sysctl_reg`

## Requirements
- R1: While any reset is applied, the read value is binary 1000_00x0, where bit 1 is the lock. With power-on reset the value is 0x82. With the ordinary reset alone, bit 1 keeps its prior value. The register takes writes again from the fourth clock edge after release.
- R2: Read bits 0 and 6 are always 0, and writing 1 to them has no effect.
- R3: Bit 1 is the password lock and drives pw_lock_o. A write sets it to the written value. Only power-on reset presets it to 1.
- R4: A write with data bit 2 = 1 while dbg_mode_i = 1 makes sys_rst_req_o high for exactly the one cycle after that write edge. The same write with dbg_mode_i = 0 gives no request.
- R5: Under the condition of R4, dbg_mode_clr_o pulses high for that same single cycle. It stays low otherwise.
- R6: Bit 2 (done_o) takes the written value. ack_i = 1 at an edge clears it. If ack_i and a write of 1 to bit 2 come in the same cycle, ack_i wins and the bit reads 0. The pulses of R4 and R5 still fire.
- R7: Bit 7 enables the debug-port pins (tap_en_o). It resets to 1 and follows writes.
- R8: Bits 5:4 drive page_sel_o and bit 3 drives upper_acc_o. Both follow writes and reset to 0.
- R9: The register changes only at a clock edge where sel_i and wr_i are both 1, or where ack_i clears bit 2. Writes during reset are ignored. rdata_o reflects the stored value combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous assert |
| rst_n | input | 1 | Ordinary system reset, active low, asynchronous assert |
| sel_i | input | 1 | Register select from the CPU |
| wr_i | input | 1 | Write strobe from the CPU |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, combinational from the stored fields |
| ack_i | input | 1 | Control unit acknowledges the done flag |
| dbg_mode_i | input | 1 | External debug-mode flag |
| pw_lock_o | output | 1 | Password lock field |
| done_o | output | 1 | ROM-work-finished flag |
| upper_acc_o | output | 1 | Upper program page enable |
| page_sel_o | output | 2 | Page select for data-space access to program memory |
| tap_en_o | output | 1 | Debug test-port pin enable |
| sys_rst_req_o | output | 1 | One-cycle internal system reset request |
| dbg_mode_clr_o | output | 1 | One-cycle strobe that clears the debug-mode flag |

## Verification
Every register field and both pulses settle one clock edge after the write or acknowledge that causes them. The driver task therefore files each expectation against the cycle after it drives the stimulus, and the monitor compares it at the falling edge of that cycle. A pulse's single-cycle width is covered by the expectation of the next step, which requires the pulse to be low again unless that step makes a new qualifying write. Reset entry is asynchronous, so the reset value is checked at the first falling edge after the reset input drops. After release the bench waits four cycles before it writes, which covers the two-stage release.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;
  localparam int unsigned REG_W  = 8;
  localparam int unsigned B_LOCK = 1;
  localparam int unsigned B_DONE = 2;
  localparam int unsigned B_UPA  = 3;
  localparam int unsigned B_PG   = 4;
  localparam int unsigned PG_W   = 2;
  localparam int unsigned B_TAP  = 7;

  typedef struct packed {
    logic            tap;
    logic [PG_W-1:0] page;
    logic            upa;
    logic            lock;
  } cfg_t;

  // Value of the ordinarily reset fields; lock position only used on power-on
  localparam logic            TAP_RST  = 1'b1;
  localparam logic [PG_W-1:0] PAGE_RST = '0;
  localparam logic            UPA_RST  = 1'b0;
  localparam logic            LOCK_POR = 1'b1;

  function automatic logic [REG_W-1:0] assemble(input cfg_t c, input logic done);
    logic [REG_W-1:0] r;
    r                = '0;
    r[B_LOCK]        = c.lock;
    r[B_DONE]        = done;
    r[B_UPA]         = c.upa;
    r[B_PG +: PG_W]  = c.page;
    r[B_TAP]         = c.tap;
    return r;
  endfunction
endpackage

// File: rtl/sysctl_rst_sync.sv
module sysctl_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  localparam int unsigned SW = (STAGES < 2) ? 2 : STAGES;

  logic [SW-1:0] sync_q;
  logic [SW-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[SW-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign srst_n = sync_q[SW-1];
endmodule

// File: rtl/sysctl_cfg_bits.sv
module sysctl_cfg_bits
  import sysctl_pkg::*;
(
  input  logic             clk,
  input  logic             any_rst_n,
  input  logic             por_rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wdata,
  output cfg_t             cfg_o
);
  logic            tap_q,  tap_d;
  logic [PG_W-1:0] page_q, page_d;
  logic            upa_q,  upa_d;
  logic            lock_q, lock_d;

  // Next-state: take write data when enabled, otherwise hold
  always_comb begin
    tap_d  = tap_q;
    page_d = page_q;
    upa_d  = upa_q;
    lock_d = lock_q;
    if (wr_en) begin
      tap_d  = wdata[B_TAP];
      page_d = wdata[B_PG +: PG_W];
      upa_d  = wdata[B_UPA];
      lock_d = wdata[B_LOCK];
    end
  end

  // Fields cleared by every reset
  always_ff @(posedge clk or negedge any_rst_n) begin
    if (!any_rst_n) begin
      tap_q  <= TAP_RST;
      page_q <= PAGE_RST;
      upa_q  <= UPA_RST;
    end else if (wr_en) begin
      tap_q  <= tap_d;
      page_q <= page_d;
      upa_q  <= upa_d;
    end
  end

  // Lock survives ordinary reset; only power-on presets it
  always_ff @(posedge clk or negedge por_rst_n) begin
    if (!por_rst_n)  lock_q <= LOCK_POR;
    else if (wr_en)  lock_q <= lock_d;
  end

  assign cfg_o = '{tap: tap_q, page: page_q, upa: upa_q, lock: lock_q};

  assert_lock_hold_R3: assert property (@(posedge clk) disable iff (!por_rst_n)
    !wr_en |=> $stable(lock_q));
  assert_lock_write_R3: assert property (@(posedge clk) disable iff (!por_rst_n)
    wr_en |=> (lock_q == $past(wdata[B_LOCK])));
  assert_tap_write_R7: assert property (@(posedge clk) disable iff (!any_rst_n)
    wr_en |=> (tap_q == $past(wdata[B_TAP])));
  assert_page_write_R8: assert property (@(posedge clk) disable iff (!any_rst_n)
    wr_en |=> (page_q == $past(wdata[B_PG +: PG_W]) && upa_q == $past(wdata[B_UPA])));
endmodule

// File: rtl/sysctl_done_hs.sv
module sysctl_done_hs (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_en,
  input  logic wr_bit,
  input  logic ack_i,
  input  logic dbg_mode_i,
  output logic done_o,
  output logic sys_rst_req_o,
  output logic dbg_clr_o
);
  logic done_q, done_d;
  logic req_q,  req_d;
  logic clr_q,  clr_d;
  logic fire;

  always_comb begin
    fire   = wr_en & wr_bit & dbg_mode_i;
    done_d = done_q;
    if (wr_en) done_d = wr_bit;
    if (ack_i) done_d = 1'b0;   // acknowledge wins over a concurrent write
    req_d  = fire;
    clr_d  = fire;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
      req_q  <= 1'b0;
      clr_q  <= 1'b0;
    end else begin
      done_q <= done_d;
      req_q  <= req_d;
      clr_q  <= clr_d;
    end
  end

  assign done_o        = done_q;
  assign sys_rst_req_o = req_q;
  assign dbg_clr_o     = clr_q;

  assert_ack_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ack_i |=> !done_q);
  assert_done_sets_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_bit && !ack_i) |=> done_q);
  assert_req_needs_dbg_R4: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst_req_o |-> $past(dbg_mode_i && wr_en));
  assert_clr_needs_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_clr_o |-> $past(wr_en && wr_bit));
endmodule

// File: rtl/sysctl_reg.sv
module sysctl_reg
  import sysctl_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             por_n,
  input  logic             rst_n,
  input  logic             sel_i,
  input  logic             wr_i,
  input  logic [REG_W-1:0] wdata_i,
  output logic [REG_W-1:0] rdata_o,
  input  logic             ack_i,
  input  logic             dbg_mode_i,
  output logic             pw_lock_o,
  output logic             done_o,
  output logic             upper_acc_o,
  output logic [PG_W-1:0]  page_sel_o,
  output logic             tap_en_o,
  output logic             sys_rst_req_o,
  output logic             dbg_mode_clr_o
);
  logic any_arst_n;
  logic any_srst_n;
  logic por_srst_n;
  logic wr_en;
  cfg_t cfg;
  logic done;

  assign any_arst_n = por_n & rst_n;

  sysctl_rst_sync #(.STAGES(SYNC_STAGES)) u_any_sync (
    .clk(clk), .arst_n(any_arst_n), .srst_n(any_srst_n));

  sysctl_rst_sync #(.STAGES(SYNC_STAGES)) u_por_sync (
    .clk(clk), .arst_n(por_n), .srst_n(por_srst_n));

  assign wr_en = sel_i & wr_i & any_srst_n;

  sysctl_cfg_bits u_cfg (
    .clk(clk), .any_rst_n(any_srst_n), .por_rst_n(por_srst_n),
    .wr_en(wr_en), .wdata(wdata_i), .cfg_o(cfg));

  sysctl_done_hs u_done (
    .clk(clk), .rst_n(any_srst_n), .wr_en(wr_en), .wr_bit(wdata_i[B_DONE]),
    .ack_i(ack_i), .dbg_mode_i(dbg_mode_i), .done_o(done),
    .sys_rst_req_o(sys_rst_req_o), .dbg_clr_o(dbg_mode_clr_o));

  assign rdata_o     = assemble(cfg, done);
  assign pw_lock_o   = cfg.lock;
  assign done_o      = done;
  assign upper_acc_o = cfg.upa;
  assign page_sel_o  = cfg.page;
  assign tap_en_o    = cfg.tap;

  assert_no_write_hold_R9: assert property (@(posedge clk) disable iff (!any_srst_n)
    (!(sel_i && wr_i) && !ack_i) |=> $stable(rdata_o));
  assert_pulses_aligned_R5: assert property (@(posedge clk) disable iff (!any_srst_n)
    sys_rst_req_o |-> dbg_mode_clr_o);
endmodule

// File: tb/sysctl_reg_test.sv
`timescale 1ns/1ps
module sysctl_reg_test;
  logic       clk = 1'b0;
  logic       por_n, rst_n, sel_i, wr_i, ack_i, dbg_mode_i;
  logic [7:0] wdata_i, rdata_o;
  logic       pw_lock_o, done_o, upper_acc_o, tap_en_o, sys_rst_req_o, dbg_mode_clr_o;
  logic [1:0] page_sel_o;

  always #2.5 clk = ~clk;

  sysctl_reg uut (
    .clk(clk), .por_n(por_n), .rst_n(rst_n), .sel_i(sel_i), .wr_i(wr_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .ack_i(ack_i), .dbg_mode_i(dbg_mode_i),
    .pw_lock_o(pw_lock_o), .done_o(done_o), .upper_acc_o(upper_acc_o),
    .page_sel_o(page_sel_o), .tap_en_o(tap_en_o), .sys_rst_req_o(sys_rst_req_o),
    .dbg_mode_clr_o(dbg_mode_clr_o));

  typedef struct {
    int         due;
    logic [7:0] rd;
    logic       pulse;
    string      tag;
  } exp_t;

  exp_t q[$];
  int   cyc = 0;
  int   n_chk = 0;
  int   n_fail = 0;

  // reference model state
  logic       m_lock, m_done, m_upa, m_tap;
  logic [1:0] m_pg;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, expv);
    end
  endtask

  function automatic logic [7:0] model_rd();
    return {m_tap, 1'b0, m_pg, m_upa, m_done, m_lock, 1'b0};
  endfunction

  task automatic compare_all(input logic [7:0] erd, input logic ep, input string tag);
    logic [7:0] flds;
    flds = {tap_en_o, 1'b0, page_sel_o, upper_acc_o, done_o, pw_lock_o, 1'b0};
    check(rdata_o === erd, {tag, " rdata"}, rdata_o, erd);
    check(flds === erd, {tag, " fields"}, flds, erd);
    check(sys_rst_req_o === ep, {tag, " sys_rst_req"}, {7'd0, sys_rst_req_o}, {7'd0, ep});
    check(dbg_mode_clr_o === ep, {tag, " dbg_clr"}, {7'd0, dbg_mode_clr_o}, {7'd0, ep});
  endtask

  // Monitor: compare expectations due in the current cycle
  always @(negedge clk) begin
    while (q.size() > 0 && q[0].due <= cyc) begin
      exp_t e;
      e = q.pop_front();
      compare_all(e.rd, e.pulse, e.tag);
    end
  end

  // Driver: one cycle of stimulus; expectation due after the next edge
  task automatic step(input logic s, input logic w, input logic [7:0] d,
                      input logic a, input logic dbg, input string tag);
    exp_t e;
    logic we, fire;
    @(posedge clk); #1;
    sel_i = s; wr_i = w; wdata_i = d; ack_i = a; dbg_mode_i = dbg;
    we   = s & w;
    fire = we & d[2] & dbg;
    if (we) begin
      m_lock = d[1]; m_done = d[2]; m_upa = d[3]; m_pg = d[5:4]; m_tap = d[7];
    end
    if (a) m_done = 1'b0;
    e.due = cyc + 1; e.rd = model_rd(); e.pulse = fire; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic idle_inputs();
    sel_i = 0; wr_i = 0; wdata_i = 8'h00; ack_i = 0; dbg_mode_i = 0;
  endtask

  task automatic settle(input int n);
    @(posedge clk); #1;
    idle_inputs();
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic apply_reset(input bit por, input string tag);
    @(posedge clk); #1;
    idle_inputs();
    if (por) begin por_n = 0; m_lock = 1; end
    rst_n = 0;
    m_done = 0; m_upa = 0; m_pg = 0; m_tap = 1;
    @(negedge clk);
    compare_all(model_rd(), 1'b0, tag);
    // R9: write attempt during reset is ignored
    sel_i = 1; wr_i = 1; wdata_i = 8'h7D;
    @(negedge clk); @(negedge clk);
    compare_all(model_rd(), 1'b0, {tag, " R9 write in reset"});
    @(posedge clk); #1;
    idle_inputs();
    por_n = 1; rst_n = 1;
    repeat (4) @(posedge clk);
    #1;
  endtask

  initial begin
    por_n = 0; rst_n = 0;
    idle_inputs();
    m_lock = 1; m_done = 0; m_upa = 0; m_pg = 0; m_tap = 1;
    repeat (3) @(negedge clk);
    compare_all(8'h82, 1'b0, "R1 R3 R7 power-on value");
    @(posedge clk); #1;
    por_n = 1; rst_n = 1;
    repeat (4) @(posedge clk);

    step(1, 1, 8'hFF, 0, 0, "R2 reserved bits ignored");
    step(1, 0, 8'h00, 0, 0, "R9 no strobe hold");
    step(0, 1, 8'h00, 0, 0, "R9 no select hold");
    step(0, 0, 8'h00, 1, 0, "R6 ack clears done");
    step(1, 1, 8'h04, 0, 1, "R4 R5 done with debug");
    step(0, 0, 8'h00, 0, 1, "R4 R5 single pulse");
    step(1, 1, 8'h04, 1, 1, "R6 ack priority");
    step(1, 1, 8'h04, 0, 0, "R4 R5 no debug no pulse");
    step(1, 1, 8'h04, 0, 1, "R4 back-to-back 1");
    step(1, 1, 8'h04, 0, 1, "R4 back-to-back 2");
    step(1, 1, 8'h00, 0, 0, "R6 write zero clears done");
    step(1, 1, 8'h38, 0, 0, "R8 R7 R3 page 3 upper tap off");
    step(1, 1, 8'h10, 0, 0, "R8 page 1");
    step(1, 1, 8'h28, 0, 0, "R8 page 2 upper");
    step(0, 0, 8'h00, 0, 0, "R9 idle");
    settle(2);

    apply_reset(0, "R1 R3 ordinary reset keeps lock 0");
    step(1, 1, 8'h02, 0, 0, "R3 lock set");
    step(0, 0, 8'h00, 0, 0, "R3 idle");
    settle(2);
    apply_reset(0, "R1 R3 ordinary reset keeps lock 1");
    step(1, 1, 8'h41, 0, 0, "R2 R3 lock clear reserved ignored");
    step(0, 0, 8'h00, 0, 0, "R2 idle");
    settle(2);
    apply_reset(1, "R1 R3 power-on presets lock");
    step(0, 0, 8'h00, 0, 0, "R1 after release");
    settle(2);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule